// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block is a bus master that sits beside a configuration item port. Software points it at a 16-byte descriptor in memory by writing a 64-bit address register. The engine reads the descriptor as four 32-bit words and decodes the control word. Depending on the control bits, it can select a new item, copy a number of bytes from the current item position into memory, or advance the item position without copying. It then writes a status word back over the descriptor's control field. Software polls that field to learn the outcome.

The address register accepts either one 64-bit write or two 32-bit writes. Only a write that covers the less significant half starts an operation. The item port is driven through a select pulse that carries a 16-bit key and resets the item position to zero. A separate advance pulse moves the position forward one byte. The current byte is presented combinationally on `blob_data`. Memory words are big-endian: the byte at the lowest address sits in bits 31:24.

Top module: `cfgdma_engine`

## Requirements
- R1: Any read of the address register returns the signature 64'h51454D5520434647. A 64-bit read at offset 0x10 returns all of it. A 32-bit read at offset 0x10 returns 32'h51454D55, and a 32-bit read at 0x14 returns 32'h20434647 in the low 32 bits.
- R2: A 32-bit write at offset 0x10 sets the upper half of the address and does not start an operation. A 32-bit write at offset 0x14 sets the lower half and starts one, and so does a 64-bit write at 0x10. The descriptor is fetched with four 32-bit reads at A, A+4, A+8 and A+12, which give the control word, the length, the upper target word and the lower target word.
- R3: The address register is zero after reset and again after every operation. A lone lower-half write therefore fetches from an address whose upper 32 bits are zero.
- R4: When control bit 3 is set, exactly one `blob_sel` pulse with key = control[31:16] is issued before any advance or data write.
- R5: When control bit 1 is set, the engine performs `length` byte writes (`mem_byte`=1, data in bits 7:0) at target+i, each carrying the current item byte. Each accepted write is followed by exactly one advance.
- R6: When control bit 2 is set and bit 1 is clear, the engine issues `length` advances and makes no memory write except the write-back.
- R7: Every operation ends with a 32-bit write to the descriptor address. The value is 0 on success. The engine is idle in the cycle after that write is accepted.
- R8: A memory error during the descriptor fetch or a data write stops the operation at once, without advancing, and the write-back value is 1 (bit 0 set).
- R9: Register writes that arrive while an operation is running are ignored.
- R10: A memory request keeps its address, direction and data stable until `mem_ready`.
- R11: A length of zero moves no data. The other control bits (including an incoming bit 0) do not change the write-back value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_offs | input | 5 | Register byte offset |
| reg_wdata | input | 64 | Write data (32-bit accesses use bits 31:0) |
| reg_rdata | output | 64 | Read data for the current offset and width |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | 1 = single-byte write, 0 = 32-bit word |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_err | input | 1 | Error response, valid with mem_ready |
| blob_sel | output | 1 | Select pulse: load key, position to zero |
| blob_key | output | 16 | Item key for blob_sel |
| blob_adv | output | 1 | Advance item position by one byte |
| blob_data | input | 8 | Byte at the current item position |
| busy | output | 1 | Operation in progress |

## Verification
The hardest cases to reach are a memory error that lands part-way through a copy and a trigger write that arrives while the engine is busy. For the first, the bench memory model flags one chosen target byte as failing. It then checks that the write-back reports bit 0, and that a follow-up copy without a select resumes at the position reached before the failed byte. For the second, response latencies of up to two cycles keep the engine busy long enough to poke both trigger forms in mid-operation. Any extra descriptor fetch that follows shows up as an unexpected scoreboard item.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
    localparam int ADDR_W = 64;
    localparam int WORD_W = 32;
    localparam int KEY_W  = 16;
    localparam int OFFS_W = 5;
    localparam int BYTE_W = 8;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W  = $clog2(DESC_WORDS);

    localparam logic [ADDR_W-1:0] SIGNATURE = 64'h5145_4D55_2043_4647;
    localparam logic [OFFS_W-1:0] OFFS_HI = 5'h10;
    localparam logic [OFFS_W-1:0] OFFS_LO = 5'h14;

    localparam int CTL_ERR  = 0;
    localparam int CTL_RD   = 1;
    localparam int CTL_SKIP = 2;
    localparam int CTL_SEL  = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_SELECT, ST_PLAN, ST_XFER, ST_WBACK
    } state_e;

    typedef enum logic {MV_COPY, MV_SKIP} move_e;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] len;
        logic [ADDR_W-1:0] target;
    } desc_t;

    function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [IDX_W-1:0] idx);
        return base + {{(ADDR_W-IDX_W-2){1'b0}}, idx, 2'b00};
    endfunction
endpackage

// File: rtl/cfgdma_addr_reg.sv
module cfgdma_addr_reg
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              wide_i,
    input  logic [OFFS_W-1:0] offs_i,
    input  logic [ADDR_W-1:0] wdata_i,
    input  logic              busy_i,
    input  logic              done_i,
    output logic [ADDR_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] dma_addr_o,
    output logic              start_o
);
    localparam int HALF = ADDR_W / 2;

    logic accept;
    assign accept = wr_i && !busy_i && !start_o;

    always_comb begin
        rdata_o = '0;
        if (offs_i == OFFS_HI && wide_i)
            rdata_o = SIGNATURE;
        else if (offs_i == OFFS_HI)
            rdata_o = {{HALF{1'b0}}, SIGNATURE[ADDR_W-1:HALF]};
        else if (offs_i == OFFS_LO && !wide_i)
            rdata_o = {{HALF{1'b0}}, SIGNATURE[HALF-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_addr_o <= '0;
            start_o    <= 1'b0;
        end else begin
            start_o <= 1'b0;
            if (done_i) begin
                dma_addr_o <= '0;
            end else if (accept) begin
                if (offs_i == OFFS_HI && wide_i) begin
                    dma_addr_o <= wdata_i;
                    start_o    <= 1'b1;
                end else if (offs_i == OFFS_HI) begin
                    dma_addr_o[ADDR_W-1:HALF] <= wdata_i[HALF-1:0];
                end else if (offs_i == OFFS_LO && !wide_i) begin
                    dma_addr_o[HALF-1:0] <= wdata_i[HALF-1:0];
                    start_o              <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfgdma_seq.sv
module cfgdma_seq
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] desc_addr_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    input  logic              mem_err_i,
    input  logic [BYTE_W-1:0] blob_data_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_byte_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              blob_sel_o,
    output logic [KEY_W-1:0]  blob_key_o,
    output logic              blob_adv_o,
    output logic              busy_o,
    output logic              done_o
);
    state_e            state;
    move_e             mode;
    desc_t             desc;
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] cnt;
    logic              fail;
    logic              last_byte;

    assign last_byte  = (cnt == desc.len - 1'b1);
    assign busy_o     = (state != ST_IDLE);
    assign blob_key_o = desc.ctrl[WORD_W-1 -: KEY_W];

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_byte_o  = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        blob_sel_o  = 1'b0;
        blob_adv_o  = 1'b0;
        done_o      = 1'b0;
        unique case (state)
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = word_addr(base, idx);
            end
            ST_SELECT: blob_sel_o = 1'b1;
            ST_XFER: begin
                if (mode == MV_COPY) begin
                    mem_req_o   = 1'b1;
                    mem_we_o    = 1'b1;
                    mem_byte_o  = 1'b1;
                    mem_addr_o  = desc.target + {{(ADDR_W-WORD_W){1'b0}}, cnt};
                    mem_wdata_o = {{(WORD_W-BYTE_W){1'b0}}, blob_data_i};
                    blob_adv_o  = mem_ready_i && !mem_err_i;
                end else begin
                    blob_adv_o = 1'b1;
                end
            end
            ST_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = base;
                mem_wdata_o = {{(WORD_W-1){1'b0}}, fail};
                done_o      = mem_ready_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            mode  <= MV_COPY;
            desc  <= '0;
            base  <= '0;
            idx   <= '0;
            cnt   <= '0;
            fail  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_i) begin
                    base  <= desc_addr_i;
                    idx   <= '0;
                    fail  <= 1'b0;
                    state <= ST_FETCH;
                end
                ST_FETCH: if (mem_ready_i) begin
                    if (mem_err_i) begin
                        fail  <= 1'b1;
                        state <= ST_WBACK;
                    end else begin
                        unique case (idx)
                            2'd0: desc.ctrl                 <= mem_rdata_i;
                            2'd1: desc.len                  <= mem_rdata_i;
                            2'd2: desc.target[ADDR_W-1:WORD_W] <= mem_rdata_i;
                            default: desc.target[WORD_W-1:0]   <= mem_rdata_i;
                        endcase
                        idx <= idx + 1'b1;
                        if (idx == IDX_W'(DESC_WORDS-1))
                            state <= desc.ctrl[CTL_SEL] ? ST_SELECT : ST_PLAN;
                    end
                end
                ST_SELECT: state <= ST_PLAN;
                ST_PLAN: begin
                    cnt <= '0;
                    if (desc.ctrl[CTL_RD] && desc.len != '0) begin
                        mode  <= MV_COPY;
                        state <= ST_XFER;
                    end else if (desc.ctrl[CTL_SKIP] && desc.len != '0) begin
                        mode  <= MV_SKIP;
                        state <= ST_XFER;
                    end else begin
                        state <= ST_WBACK;
                    end
                end
                ST_XFER: begin
                    if (mode == MV_SKIP || mem_ready_i) begin
                        if (mode == MV_COPY && mem_err_i) begin
                            fail  <= 1'b1;
                            state <= ST_WBACK;
                        end else begin
                            cnt <= cnt + 1'b1;
                            if (last_byte) state <= ST_WBACK;
                        end
                    end
                end
                ST_WBACK: if (mem_ready_i) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_wide,
    input  logic [OFFS_W-1:0] reg_offs,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic              mem_err,
    output logic              blob_sel,
    output logic [KEY_W-1:0]  blob_key,
    output logic              blob_adv,
    input  logic [BYTE_W-1:0] blob_data,
    output logic              busy
);
    logic [ADDR_W-1:0] dma_addr;
    logic              start;
    logic              done;

    cfgdma_addr_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (reg_wr),
        .wide_i     (reg_wide),
        .offs_i     (reg_offs),
        .wdata_i    (reg_wdata),
        .busy_i     (busy),
        .done_i     (done),
        .rdata_o    (reg_rdata),
        .dma_addr_o (dma_addr),
        .start_o    (start)
    );

    cfgdma_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .desc_addr_i (dma_addr),
        .mem_rdata_i (mem_rdata),
        .mem_ready_i (mem_ready),
        .mem_err_i   (mem_err),
        .blob_data_i (blob_data),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_byte_o  (mem_byte),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .blob_sel_o  (blob_sel),
        .blob_key_o  (blob_key),
        .blob_adv_o  (blob_adv),
        .busy_o      (busy),
        .done_o      (done)
    );
endmodule

// File: rtl/cfgdma_chk.sv
module cfgdma_chk
    import cfgdma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wide,
    input logic [OFFS_W-1:0] reg_offs,
    input logic [ADDR_W-1:0] reg_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_byte,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              mem_err,
    input logic              blob_sel,
    input logic              blob_adv,
    input logic              busy
);
    AST_SIG_WIDE: assert property (@(posedge clk) disable iff (rst)
        (reg_wide && reg_offs == OFFS_HI) |-> reg_rdata == 64'h5145_4D55_2043_4647); // R1

    AST_SEL_ALONE: assert property (@(posedge clk) disable iff (rst)
        blob_sel |-> (busy && !blob_adv && !mem_req)); // R4

    AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_byte) |-> (mem_we && mem_wdata[WORD_W-1:BYTE_W] == '0)); // R5

    AST_WB_ENDS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !mem_byte && mem_ready) |=> !busy); // R7

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && mem_err && !(mem_we && !mem_byte))
        |=> (mem_req && mem_we && !mem_byte && mem_wdata == 32'h1 && !blob_adv)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !blob_adv && !blob_sel)); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready && !mem_byte) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10

    AST_BYTE_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_byte && !mem_ready) |=> (mem_req && mem_byte && $stable(mem_addr))); // R10
endmodule

bind cfgdma_engine cfgdma_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wide  (reg_wide),
    .reg_offs  (reg_offs),
    .reg_rdata (reg_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_byte  (mem_byte),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_err   (mem_err),
    .blob_sel  (blob_sel),
    .blob_adv  (blob_adv),
    .busy      (busy)
);

// File: tb/cfgdma_engine_tb_top.sv
`timescale 1ns/1ps
module cfgdma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_wide = 1'b0;
    logic [4:0]  reg_offs = 5'h0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we, mem_byte;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        mem_err = 1'b0;
    logic        blob_sel, blob_adv, busy;
    logic [15:0] blob_key;
    logic [7:0]  blob_data;

    always #4 clk = ~clk;

    cfgdma_engine dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wide(reg_wide),
        .reg_offs(reg_offs), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .mem_err(mem_err), .blob_sel(blob_sel),
        .blob_key(blob_key), .blob_adv(blob_adv), .blob_data(blob_data),
        .busy(busy)
    );

    localparam logic [1:0] K_RD = 2'd0, K_BWR = 2'd1, K_WB = 2'd2, K_SEL = 2'd3;
    typedef struct packed {
        logic [1:0]  kind;
        logic [63:0] addr;
        logic [31:0] data;
        logic [7:0]  req;
    } ev_t;

    ev_t         exp_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] mem_w[longint];
    logic        err_en = 1'b0;
    logic [63:0] err_addr = '0;
    int          wait_cnt = 0;
    int          txn_n = 0;
    logic [15:0] bkey = '0;
    logic [31:0] boff = '0;
    logic [15:0] exp_key = '0;
    logic [31:0] exp_off = '0;

    function automatic logic [7:0] item_byte(input logic [15:0] k, input logic [31:0] o);
        return k[7:0] * 8'd13 + o[7:0] * 8'd7 + 8'h5A;
    endfunction

    assign blob_data = item_byte(bkey, boff);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic observe(input logic [1:0] kind, input logic [63:0] addr, input logic [31:0] data);
        ev_t e;
        n_cmp++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R9 unexpected item kind %0d: actual %h/%h expected none", kind, addr, data);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.addr != addr || e.data != data) begin
                n_bad++;
                $display("FAIL R%0d item: actual %0d/%h/%h expected %0d/%h/%h",
                         e.req, kind, addr, data, e.kind, e.addr, e.data);
            end
        end
    endtask

    // memory and item port model
    always @(negedge clk) begin
        if (mem_req) begin
            if (wait_cnt >= (txn_n % 3)) begin
                mem_ready = 1'b1;
                mem_err   = err_en && (mem_addr == err_addr);
                mem_rdata = mem_w.exists(mem_addr) ? mem_w[mem_addr] : 32'h0;
                if (!mem_we)       observe(K_RD, mem_addr, 32'h0);
                else if (mem_byte) observe(K_BWR, mem_addr, mem_wdata);
                else               observe(K_WB, mem_addr, mem_wdata);
                wait_cnt = 0;
                txn_n++;
            end else begin
                mem_ready = 1'b0;
                mem_err   = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_ready = 1'b0;
            mem_err   = 1'b0;
        end
        #1;
        if (blob_sel) begin
            observe(K_SEL, {48'h0, blob_key}, 32'h0);
            bkey = blob_key;
            boff = '0;
        end else if (blob_adv) begin
            boff = boff + 1;
        end
    end

    task automatic push(input logic [1:0] k, input logic [63:0] a, input logic [31:0] d, input logic [7:0] r);
        ev_t e;
        e.kind = k; e.addr = a; e.data = d; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic reg_write(input logic [4:0] offs, input logic wide, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_offs = offs; reg_wide = wide; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R7", "items left after operation", exp_q.size(), 0);
    endtask

    // how: 0 = one 64-bit write, 1 = upper then lower half, 2 = lower half only
    task automatic run_op(input logic [63:0] da, input logic [31:0] ctl, input logic [31:0] len,
                          input logic [63:0] tgt, input int how, input bit poke);
        bit failed = 0;
        mem_w[da]      = ctl;
        mem_w[da + 4]  = len;
        mem_w[da + 8]  = tgt[63:32];
        mem_w[da + 12] = tgt[31:0];
        for (int i = 0; i < 4 && !failed; i++) begin
            push(K_RD, da + 64'(4 * i), 32'h0, 8'd2);
            if (err_en && err_addr == da + 64'(4 * i)) failed = 1;
        end
        if (!failed) begin
            if (ctl[3]) begin
                push(K_SEL, {48'h0, ctl[31:16]}, 32'h0, 8'd4);
                exp_key = ctl[31:16];
                exp_off = '0;
            end
            if (ctl[1]) begin
                for (int i = 0; i < int'(len) && !failed; i++) begin
                    push(K_BWR, tgt + 64'(i), {24'h0, item_byte(exp_key, exp_off)}, 8'd5);
                    if (err_en && err_addr == tgt + 64'(i)) failed = 1;
                    else exp_off = exp_off + 1;
                end
            end else if (ctl[2]) begin
                exp_off = exp_off + len;
            end
        end
        push(K_WB, da, {31'h0, failed}, failed ? 8'd8 : 8'd7);
        if (how == 0) begin
            reg_write(5'h10, 1'b1, da);
        end else begin
            if (how == 1) begin
                reg_write(5'h10, 1'b0, {32'h0, da[63:32]});
                repeat (4) @(negedge clk);
                check(busy == 1'b0, "R2", "upper-half write started op", busy, 0);
            end
            reg_write(5'h14, 1'b0, {32'h0, da[31:0]});
        end
        if (poke) begin
            repeat (4) @(negedge clk);
            check(busy == 1'b1, "R9", "busy during op", busy, 1);
            reg_write(5'h14, 1'b0, 64'h0000_0000_0000_7700);
            reg_write(5'h10, 1'b1, 64'h0000_0000_0000_7800);
        end
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && mem_req == 1'b0, "R7", "idle after reset", {busy, mem_req}, 0);
        reg_offs = 5'h10; reg_wide = 1'b1; #1;
        check(reg_rdata == 64'h5145_4D55_2043_4647, "R1", "wide signature", reg_rdata, 64'h5145_4D55_2043_4647);
        reg_wide = 1'b0; #1;
        check(reg_rdata[31:0] == 32'h5145_4D55, "R1", "upper signature half", reg_rdata, 32'h5145_4D55);
        reg_offs = 5'h14; #1;
        check(reg_rdata[31:0] == 32'h2043_4647, "R1", "lower signature half", reg_rdata, 32'h2043_4647);

        // R3 at reset: lone lower write uses zero upper half
        run_op(64'h0000_0000_0000_0040, 32'h0002_0008, 32'd2, 64'h0000_0000_0000_1000, 2, 0);
        // R2 split write, R4 select then R5 copy
        run_op(64'h0000_0001_0000_0100, 32'h0005_000A, 32'd4, 64'h0000_0000_0000_2000, 1, 0);
        // R3 after op: lower-only write, copy continues at offset 4
        run_op(64'h0000_0000_0000_0300, 32'h0000_0002, 32'd3, 64'h0000_0000_0000_2100, 2, 0);
        // R6 skip with wide trigger, then copy shows advanced offset
        run_op(64'h0000_0002_0000_0400, 32'h0000_0004, 32'd5, 64'h0000_0000_0000_9000, 0, 0);
        run_op(64'h0000_0000_0000_0500, 32'h0000_0002, 32'd2, 64'h0000_0000_0000_2200, 0, 0);
        // select + skip, then read and skip both set (copy wins)
        run_op(64'h0000_0000_0000_0600, 32'h0009_000C, 32'd3, 64'h0000_0000_0000_9100, 0, 0);
        run_op(64'h0000_0000_0000_0700, 32'h0000_0006, 32'd2, 64'h0000_0000_0000_2300, 0, 0);
        // R11 zero length with select and incoming error bit
        run_op(64'h0000_0000_0000_0800, 32'h0021_000B, 32'd0, 64'h0000_0000_0000_2400, 0, 0);
        // R8 fetch error
        err_en = 1'b1; err_addr = 64'h0000_0000_0000_0908;
        run_op(64'h0000_0000_0000_0900, 32'h0003_000A, 32'd4, 64'h0000_0000_0000_2500, 0, 0);
        // R8 data error part-way through a copy
        err_addr = 64'h0000_0000_0000_2601;
        run_op(64'h0000_0000_0000_0A00, 32'h0003_000A, 32'd4, 64'h0000_0000_0000_2600, 0, 0);
        err_en = 1'b0;
        run_op(64'h0000_0000_0000_0B00, 32'h0000_0002, 32'd2, 64'h0000_0000_0000_2700, 0, 0);
        // R9 trigger writes during a busy operation are ignored
        run_op(64'h0000_0000_0000_0C00, 32'h0004_000A, 32'd6, 64'h0000_0000_0000_2800, 0, 1);
        repeat (20) @(negedge clk);
        check(busy == 1'b0 && exp_q.size() == 0, "R9", "no op from ignored writes", busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule